// File: doc/BRIEF.md
# Watchdog Timer with Write-Protected Control

This block supervises software by counting slow time-base ticks. Software must keep refreshing the block by setting its enable bit. If it fails to do so within the selected period, the block either requests a system reset or raises an interrupt. The period is chosen by a 4-bit exponent field. One exponent value forces a reset straight away. The exponent values above that one are refused.

All control sits in one 8-bit register. A bus write reaches the register only when the bus access just before it was a write that set the unlock bit. Any other access in between, read or write, cancels that permission. The timeout flag is sticky. Only software or the hardware reset can clear it, so the block's own reset request leaves it set. A power-monitor event turns the watchdog off at once.

The slow tick arrives as a one-cycle enable in the system clock domain. The reset request is a one-cycle pulse. The interrupt request is a level that stays high until software clears the flag. It has no mask path, so nothing can block it.

Top module: `wdt_guarded`

## Requirements
- R1: After hardware reset the register reads 0x10 and both request outputs are low. The register layout is: bits 7:4 exponent E, bit 3 interrupt select, bit 2 timeout flag, bit 1 enable, bit 0 unlock state.
- R2: A write takes effect only when the bus access just before it was a write with bit 0 set. Idle cycles between the two accesses do not cancel the permission. While the permission is pending, bit 0 reads 1. A write with no permission only loads the unlock state and leaves bits 7:1 unchanged.
- R3: A committing write uses up the permission. A read access also cancels a pending permission. A write after either one has no effect on bits 7:1.
- R4: In reset mode (bit 3 = 0), with E from 0 to 7, the reset request goes high on the 2^(E+9)-th tick after the enabling write. It then stays high for exactly one cycle.
- R5: The count advances only on cycles where the tick input is high. A committing write with bit 1 = 1 restarts the count from zero.
- R6: In interrupt mode (bit 3 = 1), a timeout raises the interrupt request and no reset request. The enable bit stays set, the count restarts, and the interrupt stays high until a committing write with bit 2 = 0.
- R7: A timeout sets the flag (bit 2). The flag survives the block's own reset request. A committing write with bit 2 = 0 clears it, and writing 1 to it keeps its current value. Hardware reset clears it.
- R8: The enable bit is cleared by a reset-mode timeout, by a power-monitor event, or by a committing write with bit 1 = 0.
- R9: With E = 8 and the enable bit set, a reset request is raised in the cycle after the enabling write, whatever bit 3 holds. The interrupt request stays low.
- R10: A committing write whose bits 7:4 exceed 8 leaves E unchanged. Bits 3:1 are still written.
- R11: While the enable bit is 0, neither request is ever raised, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert, release already synchronized |
| tick_i | input | 1 | One-cycle enable from the slow time base |
| bus_valid_i | input | 1 | A register access occurs this cycle |
| bus_wr_i | input | 1 | The access is a write (1) or a read (0) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Current register contents |
| pwr_evt_i | input | 1 | Power-monitor event, disables the watchdog |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| wdt_irq_o | output | 1 | Interrupt request level |

## Verification
The properties assume that each bus access lasts exactly one cycle, with valid, write strobe and data held across that edge. They also assume that the tick input is a synchronous enable and not a slow clock. The immediate-reset and power-event properties assume that no bus access arrives in the cycle they examine. The directed tests drive every input at the falling clock edge. Each test runs one access per cycle through write and read tasks, raises the power event for a single cycle, and holds the tick input either steadily high or steadily low in long runs. This keeps the stimulus inside those assumptions.

// File: rtl/wdt_guarded_pkg.sv
package wdt_guarded_pkg;
  localparam int REG_W   = 8;
  localparam int PRE_W   = 4;
  localparam int PRE_LSB = 4;
  localparam int IRQ_BIT = 3;
  localparam int STS_BIT = 2;
  localparam int EN_BIT  = 1;
  localparam int ARM_BIT = 0;

  // exponent value that forces an immediate reset; anything above is refused
  localparam logic [PRE_W-1:0] PRE_IMM   = 4'd8;
  localparam logic [PRE_W-1:0] PRE_RESET = 4'd1;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             irq_sel;
    logic             status;
    logic             enable;
    logic             armed;
  } ctrl_view_t;
endpackage

// File: rtl/wdt_arm.sv
// Tracks the one-shot write permission: a write carrying the unlock bit arms it,
// the next access of any kind disarms it, and only an armed write commits.
module wdt_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic wr_i,
  input  logic unlock_i,
  output logic armed_o,
  output logic commit_o
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (acc_i) begin
      armed_d = wr_i && !armed_q && unlock_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed_o  = armed_q;
  assign commit_o = acc_i && wr_i && armed_q;
endmodule

// File: rtl/wdt_period_cnt.sv
// Tick counter with a power-of-two terminal count picked by the exponent.
// Needs CNT_W >= BASE_EXP + 2**SEL_W - 1 so the largest period fits.
module wdt_period_cnt #(
  parameter int CNT_W    = 16,
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int SPAN_W = CNT_W + 1;

  logic [SPAN_W-1:0] span;
  logic [CNT_W-1:0]  last;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              at_last;
  logic              cnt_en;

  always_comb begin
    span = SPAN_W'(1) << (int'(sel_i) + BASE_EXP);
    last = CNT_W'(span - SPAN_W'(1));
  end

  assign at_last  = (cnt_q == last);
  assign expire_o = run_i && tick_i && at_last && !clear_i;
  assign cnt_en   = clear_i || !run_i || tick_i;

  always_comb begin
    if (clear_i || !run_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
// Control fields, timeout decision and the two request outputs.
module wdt_ctrl
  import wdt_guarded_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [PRE_W-1:0] wpre_i,
  input  logic             wirq_i,
  input  logic             wsts_i,
  input  logic             wen_i,
  input  logic             pwr_evt_i,
  input  logic             expire_i,
  output logic [PRE_W-1:0] pre_o,
  output logic             irq_sel_o,
  output logic             status_o,
  output logic             enable_o,
  output logic             kick_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  logic [PRE_W-1:0] pre_q;
  logic             irq_sel_q, status_q, enable_q, irq_q, rst_q;
  logic             status_d, enable_d, irq_d;
  logic             pre_we, imm, timed_out, to_reset, to_irq, sts_clr;

  assign pre_we    = commit_i && (wpre_i <= PRE_IMM);
  assign imm       = (pre_q == PRE_IMM);
  assign timed_out = enable_q && !commit_i && !pwr_evt_i && (imm || expire_i);
  assign to_reset  = timed_out && (!irq_sel_q || imm);
  assign to_irq    = timed_out && !to_reset;
  assign sts_clr   = commit_i && !wsts_i;
  assign kick_o    = commit_i && wen_i && !pwr_evt_i;

  always_comb begin
    enable_d = enable_q;
    if (pwr_evt_i) begin
      enable_d = 1'b0;
    end else if (commit_i) begin
      enable_d = wen_i;
    end else if (to_reset) begin
      enable_d = 1'b0;
    end

    status_d = status_q;
    if (sts_clr) begin
      status_d = 1'b0;
    end else if (timed_out) begin
      status_d = 1'b1;
    end

    irq_d = irq_q;
    if (sts_clr) begin
      irq_d = 1'b0;
    end else if (to_irq) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= PRE_RESET;
      irq_sel_q <= 1'b0;
      status_q  <= 1'b0;
      enable_q  <= 1'b0;
      irq_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      if (pre_we) begin
        pre_q <= wpre_i;
      end
      if (commit_i) begin
        irq_sel_q <= wirq_i;
      end
      status_q <= status_d;
      enable_q <= enable_d;
      irq_q    <= irq_d;
      rst_q    <= to_reset;
    end
  end

  assign pre_o     = pre_q;
  assign irq_sel_o = irq_sel_q;
  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
  import wdt_guarded_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BASE_EXP = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_valid_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             pwr_evt_i,
  output logic             sys_rst_req_o,
  output logic             wdt_irq_o
);
  localparam int SEL_W = PRE_W - 1;

  logic             armed, commit, expire, kick;
  logic [PRE_W-1:0] pre;
  logic             irq_sel, status, enable;
  ctrl_view_t       view;

  wdt_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (bus_valid_i),
    .wr_i     (bus_wr_i),
    .unlock_i (bus_wdata_i[ARM_BIT]),
    .armed_o  (armed),
    .commit_o (commit)
  );

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .wpre_i    (bus_wdata_i[PRE_LSB +: PRE_W]),
    .wirq_i    (bus_wdata_i[IRQ_BIT]),
    .wsts_i    (bus_wdata_i[STS_BIT]),
    .wen_i     (bus_wdata_i[EN_BIT]),
    .pwr_evt_i (pwr_evt_i),
    .expire_i  (expire),
    .pre_o     (pre),
    .irq_sel_o (irq_sel),
    .status_o  (status),
    .enable_o  (enable),
    .kick_o    (kick),
    .rst_req_o (sys_rst_req_o),
    .irq_o     (wdt_irq_o)
  );

  wdt_period_cnt #(
    .CNT_W    (CNT_W),
    .BASE_EXP (BASE_EXP),
    .SEL_W    (SEL_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (enable),
    .clear_i  (kick || pwr_evt_i),
    .sel_i    (pre[SEL_W-1:0]),
    .expire_o (expire)
  );

  always_comb begin
    view.pre     = pre;
    view.irq_sel = irq_sel;
    view.status  = status;
    view.enable  = enable;
    view.armed   = armed;
  end

  assign bus_rdata_o = view;
endmodule

// File: rtl/wdt_guarded_chk.sv
module wdt_guarded_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid_i,
  input logic       bus_wr_i,
  input logic [3:0] wpre_i,
  input logic [7:0] bus_rdata_o,
  input logic       pwr_evt_i,
  input logic       sys_rst_req_o,
  input logic       wdt_irq_o
);
  p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o);

  p_reset_leaves_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> (bus_rdata_o[2] && !bus_rdata_o[1]));

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq_o |-> bus_rdata_o[2]);

  p_locked_write_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_wr_i && !bus_rdata_o[0]) |=> $stable(bus_rdata_o[7:3]));

  p_read_cancels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_wr_i) |=> !bus_rdata_o[0]);

  p_power_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt_i |=> !bus_rdata_o[1]);

  p_immediate_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_o[7:4] == 4'd8 && bus_rdata_o[1] && !bus_valid_i && !pwr_evt_i)
      |=> sys_rst_req_o);

  p_reserved_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_wr_i && bus_rdata_o[0] && wpre_i > 4'd8)
      |=> $stable(bus_rdata_o[7:4]));

  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_o[1] |=> !sys_rst_req_o);
endmodule

bind wdt_guarded wdt_guarded_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid_i   (bus_valid_i),
  .bus_wr_i      (bus_wr_i),
  .wpre_i        (bus_wdata_i[7:4]),
  .bus_rdata_o   (bus_rdata_o),
  .pwr_evt_i     (pwr_evt_i),
  .sys_rst_req_o (sys_rst_req_o),
  .wdt_irq_o     (wdt_irq_o)
);

// File: tb/tb_wdt_guarded.sv
`timescale 1ns/1ps
module tb_wdt_guarded;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pwr_evt = 1'b0;
  logic       rst_req;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int rst_seen = 0;

  always #2 clk = ~clk;

  wdt_guarded dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick),
    .bus_valid_i   (bus_valid),
    .bus_wr_i      (bus_wr),
    .bus_wdata_i   (bus_wdata),
    .bus_rdata_o   (bus_rdata),
    .pwr_evt_i     (pwr_evt),
    .sys_rst_req_o (rst_req),
    .wdt_irq_o     (irq)
  );

  always @(posedge clk) if (rst_n && rst_req) rst_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_valid = 1'b0; bus_wr = 1'b0; pwr_evt = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read();
    bus_valid = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic prot_write(input logic [7:0] d);
    bus_write(8'h01);
    bus_write(d);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 reset value", bus_rdata, 8'h10);
    check("R1 reset req low", rst_req, 1'b0);
    check("R1 irq low", irq, 1'b0);
  endtask

  task automatic t_unlock();
    do_reset();
    bus_write(8'h32);
    check("R2 write without unlock", bus_rdata, 8'h10);
    bus_write(8'h01);
    check("R2 armed readback", bus_rdata, 8'h11);
    repeat (3) @(negedge clk);
    bus_write(8'h30);
    check("R2 commit after idle gap", bus_rdata, 8'h30);
    bus_write(8'h50);
    check("R3 permission spent", bus_rdata, 8'h30);
    bus_write(8'h01);
    bus_read();
    check("R3 read disarms", bus_rdata, 8'h30);
    bus_write(8'h50);
    check("R3 write after read inert", bus_rdata, 8'h30);
  endtask

  task automatic t_reset_timeout();
    do_reset();
    prot_write(8'h02);
    check("R4 enabled", bus_rdata, 8'h02);
    repeat (511) @(negedge clk);
    check("R4 no request before period", rst_req, 1'b0);
    @(negedge clk);
    check("R4 request at period", rst_req, 1'b1);
    check("R8 R7 flag set enable cleared", bus_rdata, 8'h04);
    @(negedge clk);
    check("R4 single-cycle pulse", rst_req, 1'b0);
    repeat (20) @(negedge clk);
    check("R7 flag survives own reset", bus_rdata, 8'h04);
    prot_write(8'h04);
    check("R7 writing 1 keeps flag", bus_rdata, 8'h04);
    prot_write(8'h00);
    check("R7 write 0 clears flag", bus_rdata, 8'h00);
    prot_write(8'h02);
    repeat (512) @(negedge clk);
    check("R7 flag set again", bus_rdata[2], 1'b1);
    do_reset();
    check("R7 hardware reset clears flag", bus_rdata, 8'h10);
  endtask

  task automatic t_tick_gating();
    int seen0;
    do_reset();
    tick = 1'b0;
    seen0 = rst_seen;
    prot_write(8'h02);
    repeat (1000) @(negedge clk);
    check("R5 no ticks no timeout", rst_seen - seen0, 0);
    tick = 1'b1;
    repeat (400) @(negedge clk);
    tick = 1'b0;
    repeat (50) @(negedge clk);
    check("R5 partial count", rst_seen - seen0, 0);
    tick = 1'b1;
    prot_write(8'h02);
    repeat (511) @(negedge clk);
    check("R5 kick restarted count", rst_seen - seen0, 0);
    @(negedge clk);
    check("R5 timeout 512 ticks after kick", rst_req, 1'b1);
  endtask

  task automatic t_irq_mode();
    int seen0;
    do_reset();
    seen0 = rst_seen;
    prot_write(8'h0A);
    repeat (511) @(negedge clk);
    check("R6 irq not before period", irq, 1'b0);
    @(negedge clk);
    check("R6 irq raised", irq, 1'b1);
    check("R6 fields after irq timeout", bus_rdata, 8'h0E);
    repeat (600) @(negedge clk);
    check("R6 irq level held", irq, 1'b1);
    check("R6 no reset request", rst_seen - seen0, 0);
    check("R6 enable kept", bus_rdata[1], 1'b1);
    prot_write(8'h0A);
    check("R6 irq cleared with flag", irq, 1'b0);
    check("R6 fields after clear", bus_rdata, 8'h0A);
  endtask

  task automatic t_immediate();
    do_reset();
    prot_write(8'h82);
    check("R9 not at commit edge", rst_req, 1'b0);
    @(negedge clk);
    check("R9 immediate request", rst_req, 1'b1);
    check("R9 fields", bus_rdata, 8'h84);
    prot_write(8'h8A);
    @(negedge clk);
    check("R9 reset even in irq mode", rst_req, 1'b1);
    check("R9 irq stays low", irq, 1'b0);
    check("R9 fields irq mode", bus_rdata, 8'h8C);
  endtask

  task automatic t_reserved();
    do_reset();
    prot_write(8'h98);
    check("R10 exponent 9 refused", bus_rdata, 8'h18);
    prot_write(8'h38);
    prot_write(8'hC0);
    check("R10 exponent 12 refused", bus_rdata, 8'h30);
  endtask

  task automatic t_disabled();
    int seen0;
    do_reset();
    seen0 = rst_seen;
    repeat (2000) @(negedge clk);
    check("R11 idle after reset", rst_seen - seen0, 0);
    prot_write(8'h00);
    repeat (1200) @(negedge clk);
    check("R11 exponent 0 disabled", rst_seen - seen0, 0);
    check("R11 irq low", irq, 1'b0);
  endtask

  task automatic t_power();
    int seen0;
    do_reset();
    seen0 = rst_seen;
    prot_write(8'h02);
    repeat (100) @(negedge clk);
    pwr_evt = 1'b1;
    @(negedge clk);
    pwr_evt = 1'b0;
    check("R8 power event disables", bus_rdata[1], 1'b0);
    repeat (700) @(negedge clk);
    check("R8 no timeout after power event", rst_seen - seen0, 0);
    prot_write(8'h02);
    prot_write(8'h00);
    check("R8 write 0 disables", bus_rdata[1], 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_unlock();
    t_reset_timeout();
    t_tick_gating();
    t_irq_mode();
    t_immediate();
    t_reserved();
    t_disabled();
    t_power();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule